// File: doc/BRIEF.md
# Memory Ordering Buffer for Loads and Stores

This block sits between address generation and a single memory request port. Memory operations arrive in program order, one per cycle, with their effective addresses already computed. Loads wait in a load queue and stores in a store queue. Each entry is then sent to memory as soon as nothing older stands in its way. The buffer compares addresses against every operation still in flight, so a load can pass an older store to a different address, and loads can pass each other freely.

A store may arrive before its data exists. In that case it carries the tag of the producing operation and watches a result broadcast bus until that tag appears. A store also waits while any older load or older store to the same address is still pending, which keeps write-after-read and write-after-write order at each address. When several entries are eligible in one cycle, the oldest eligible entry gets the port. An entry stays in the buffer until the port accepts it.

Top module: `ldst_order_buf`

## Requirements
- R1: After reset both queues are empty. `alloc_ready` is 1 for either kind of operation and `mem_req_valid` is 0.
- R2: A load allocated into an empty buffer is presented on the memory port in the cycle after allocation, with `mem_req_write`=0, its address, its id, and `mem_req_data`=0.
- R3: A load is not presented while an older pending store has the same address. It is presented once that store has been accepted. A load whose address differs from every older pending store is not held back.
- R4: A load is never held back by an older load. A younger load may go to memory before an older, blocked load, and two loads to the same address go out on consecutive accepting cycles.
- R5: A store is not presented before its data is available. Data is available when it comes with the allocation (`alloc_data_ok`=1), or when `bc_valid` is seen with `bc_tag` equal to the store's tag. This includes a broadcast in the allocation cycle itself. The captured value is the value sent.
- R6: A store is not presented while an older pending load or store has the same address.
- R7: When several entries are eligible in the same cycle, the oldest one in allocation order is presented. An older entry that becomes eligible takes the port from a younger one that was being presented.
- R8: Each queue has 4 entries. `alloc_ready` (for the kind given by `alloc_is_store`) is 0 while the matching queue is full. An `alloc_valid` while `alloc_ready` is 0 allocates nothing.
- R9: A presented store drives `mem_req_write`=1 with its address, id and data value.
- R10: An entry leaves the buffer on the edge where `mem_req_valid` and `mem_req_ready` are both 1. Its slot can be allocated again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | New memory operation offered |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_addr | input | 16 | Effective address |
| alloc_id | input | 6 | Operation identifier returned on the memory port |
| alloc_data_ok | input | 1 | Store data is supplied with the allocation |
| alloc_data | input | 32 | Store data value when `alloc_data_ok`=1 |
| alloc_tag | input | 4 | Producer tag of store data when `alloc_data_ok`=0 |
| alloc_ready | output | 1 | The queue selected by `alloc_is_store` has a free entry |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 4 | Producer tag of the broadcast result |
| bc_data | input | 32 | Broadcast result value |
| mem_req_valid | output | 1 | A memory request is presented |
| mem_req_ready | input | 1 | Memory port accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | 16 | Request address |
| mem_req_data | output | 32 | Store data (0 for loads) |
| mem_req_id | output | 6 | Identifier of the presented operation |

## Verification
A wrong age bit or a stale address compare shows up on the port in the very next cycle. Either a request appears whose id breaks program order at one address, or the port falls silent while an eligible entry waits. A store that missed its broadcast never leaves, which shows as a missing request and, a few allocations later, as `alloc_ready` stuck low. A slot that is not freed on acceptance shows the same id presented twice, or a full indication one entry early.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned TAG_W  = 4;
    localparam int unsigned ID_W   = 6;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [ID_W-1:0]     id;
    } mem_req_t;

    // Position of the single set bit of a one-hot vector (0 when empty).
    function automatic logic [4:0] oh_index(input logic [31:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = r | 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ldst_free_find.sv
module ldst_free_find #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] busy,
    output logic         any_free,
    output logic [W-1:0] pick
);
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < W; i++) begin
            if (!busy[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign any_free = ~&busy;
endmodule

// File: rtl/ldst_slot.sv
module ldst_slot
    import ldst_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [ID_W-1:0]   w_id,
    input  logic [N-1:0]      w_older,
    input  logic              leave,
    input  logic [N-1:0]      gone,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [ID_W-1:0]   id,
    output logic [N-1:0]      older
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            id    <= '0;
            older <= '0;
        end else if (we) begin
            valid <= 1'b1;
            addr  <= w_addr;
            id    <= w_id;
            older <= w_older;
        end else begin
            if (leave) valid <= 1'b0;
            older <= older & ~gone;
        end
    end
endmodule

// File: rtl/ldst_data_cap.sv
module ldst_data_cap
    import ldst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              w_ok,
    input  logic [DATA_W-1:0] w_data,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              data_ok,
    output logic [DATA_W-1:0] data
);
    logic [TAG_W-1:0] tag;
    logic             hit_new;
    logic             hit_held;

    assign hit_new  = bc_valid && (bc_tag == w_tag);
    assign hit_held = bc_valid && (bc_tag == tag) && !data_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_ok <= 1'b0;
            data    <= '0;
            tag     <= '0;
        end else if (we) begin
            tag     <= w_tag;
            data_ok <= w_ok || hit_new;
            data    <= w_ok ? w_data : bc_data;
        end else if (hit_held) begin
            data_ok <= 1'b1;
            data    <= bc_data;
        end
    end
endmodule

// File: rtl/ldst_pick.sv
module ldst_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] ready,
    input  logic [N-1:0] older [N],
    output logic [N-1:0] grant,
    output logic         any
);
    for (genvar i = 0; i < N; i++) begin : g_grant
        assign grant[i] = ready[i] && !(|(ready & older[i]));
    end
    assign any = |ready;
endmodule

// File: rtl/ldst_order_buf.sv
module ldst_order_buf
    import ldst_pkg::*;
#(
    parameter int unsigned LQ_DEPTH = 4,
    parameter int unsigned SQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic              alloc_data_ok,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_ready,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    output logic [ID_W-1:0]   mem_req_id
);
    localparam int unsigned N     = LQ_DEPTH + SQ_DEPTH;
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [N-1:0] ST_MASK = {{SQ_DEPTH{1'b1}}, {LQ_DEPTH{1'b0}}};

    logic [N-1:0]      slot_valid;
    logic [ADDR_W-1:0] slot_addr  [N];
    logic [ID_W-1:0]   slot_id    [N];
    logic [N-1:0]      slot_older [N];
    logic [N-1:0]      slot_data_ok;
    logic [DATA_W-1:0] slot_data  [N];
    logic [N-1:0]      slot_ready;
    logic [N-1:0]      grant;
    logic              grant_any;
    logic [IDX_W-1:0]  grant_idx;
    logic [N-1:0]      gone;
    logic              fire;

    logic              ld_free_any;
    logic              st_free_any;
    logic [LQ_DEPTH-1:0] ld_pick;
    logic [SQ_DEPTH-1:0] st_pick;
    logic [N-1:0]      slot_we;
    logic              alloc_ok;
    logic [N-1:0]      new_older;

    // ---------------- allocation ----------------
    ldst_free_find #(.W(LQ_DEPTH)) u_ld_free (
        .busy     (slot_valid[LQ_DEPTH-1:0]),
        .any_free (ld_free_any),
        .pick     (ld_pick)
    );

    ldst_free_find #(.W(SQ_DEPTH)) u_st_free (
        .busy     (slot_valid[N-1:LQ_DEPTH]),
        .any_free (st_free_any),
        .pick     (st_pick)
    );

    assign alloc_ready = (op_kind_e'(alloc_is_store) == OP_STORE) ? st_free_any : ld_free_any;
    assign alloc_ok    = alloc_valid && alloc_ready;
    assign slot_we     = !alloc_ok ? '0 :
                         alloc_is_store ? {st_pick, {LQ_DEPTH{1'b0}}}
                                        : {{SQ_DEPTH{1'b0}}, ld_pick};

    // Every entry still present after this edge is older than the new one.
    assign fire      = grant_any && mem_req_ready;
    assign gone      = fire ? grant : '0;
    assign new_older = slot_valid & ~gone;

    // ---------------- entries ----------------
    for (genvar i = 0; i < N; i++) begin : g_slot
        ldst_slot #(.N(N)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .we      (slot_we[i]),
            .w_addr  (alloc_addr),
            .w_id    (alloc_id),
            .w_older (new_older),
            .leave   (gone[i]),
            .gone    (gone),
            .valid   (slot_valid[i]),
            .addr    (slot_addr[i]),
            .id      (slot_id[i]),
            .older   (slot_older[i])
        );

        if (i >= LQ_DEPTH) begin : g_store
            ldst_data_cap u_cap (
                .clk      (clk),
                .rst      (rst),
                .we       (slot_we[i]),
                .w_ok     (alloc_data_ok),
                .w_data   (alloc_data),
                .w_tag    (alloc_tag),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .bc_data  (bc_data),
                .data_ok  (slot_data_ok[i]),
                .data     (slot_data[i])
            );
        end else begin : g_load
            assign slot_data_ok[i] = 1'b1;
            assign slot_data[i]    = '0;
        end

        // Address conflict against older in-flight operations.
        // Loads only look at stores; stores look at everything.
        logic [N-1:0] same_addr;
        logic [N-1:0] kinds;
        logic         blocked;

        for (genvar j = 0; j < N; j++) begin : g_cmp
            assign same_addr[j] = slot_valid[j] && (slot_addr[j] == slot_addr[i]);
        end

        assign kinds      = (i >= LQ_DEPTH) ? {N{1'b1}} : ST_MASK;
        assign blocked    = |(slot_older[i] & same_addr & kinds);
        assign slot_ready[i] = slot_valid[i] && slot_data_ok[i] && !blocked;
    end

    // ---------------- oldest-ready arbitration ----------------
    ldst_pick #(.N(N)) u_pick (
        .ready (slot_ready),
        .older (slot_older),
        .grant (grant),
        .any   (grant_any)
    );

    assign grant_idx = IDX_W'(oh_index(32'(grant)));

    mem_req_t req;
    always_comb begin
        req.kind = (grant_idx >= IDX_W'(LQ_DEPTH)) ? OP_STORE : OP_LOAD;
        req.addr = slot_addr[grant_idx];
        req.id   = slot_id[grant_idx];
        req.data = slot_data[grant_idx];
    end

    assign mem_req_valid = grant_any;
    assign mem_req_write = (req.kind == OP_STORE);
    assign mem_req_addr  = req.addr;
    assign mem_req_data  = req.data;
    assign mem_req_id    = req.id;

endmodule

// File: rtl/ldst_order_buf_chk.sv
module ldst_order_buf_chk
    import ldst_pkg::*;
#(
    parameter int unsigned LQ_DEPTH = 4,
    parameter int unsigned SQ_DEPTH = 4,
    localparam int unsigned N = LQ_DEPTH + SQ_DEPTH
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_is_store,
    input logic              alloc_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [N-1:0]      slot_valid,
    input logic [N-1:0]      slot_data_ok,
    input logic [N-1:0]      grant,
    input logic [N-1:0]      slot_older [N],
    input logic [ADDR_W-1:0] slot_addr  [N]
);
    // R7: one entry at most owns the port, and the port is driven exactly then
    a_r7_single_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (mem_req_valid == (grant != '0)));

    // R10: an accepted entry is gone on the following cycle
    a_r10_slot_freed: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> ((slot_valid & $past(grant)) == '0));

    // R8: the load queue reports full only when all its slots are taken
    a_r8_load_full: assert property (@(posedge clk) disable iff (rst)
        (!alloc_is_store && !alloc_ready) |-> (&slot_valid[LQ_DEPTH-1:0]));

    // R8: same for the store queue
    a_r8_store_full: assert property (@(posedge clk) disable iff (rst)
        (alloc_is_store && !alloc_ready) |-> (&slot_valid[N-1:LQ_DEPTH]));

    for (genvar s = LQ_DEPTH; s < N; s++) begin : g_st
        // R5: a store on the port has its data
        a_r5_store_data: assert property (@(posedge clk) disable iff (rst)
            grant[s] |-> slot_data_ok[s]);

        for (genvar j = 0; j < N; j++) begin : g_any
            // R6: no older pending access to the same address
            a_r6_store_order: assert property (@(posedge clk) disable iff (rst)
                (grant[s] && slot_valid[j] && slot_older[s][j]) |->
                (slot_addr[j] != slot_addr[s]));
        end
    end

    for (genvar l = 0; l < LQ_DEPTH; l++) begin : g_ld
        for (genvar s = LQ_DEPTH; s < N; s++) begin : g_vs
            // R3: no older pending store to the same address
            a_r3_load_order: assert property (@(posedge clk) disable iff (rst)
                (grant[l] && slot_valid[s] && slot_older[l][s]) |->
                (slot_addr[s] != slot_addr[l]));
        end
    end
endmodule

bind ldst_order_buf ldst_order_buf_chk #(
    .LQ_DEPTH (LQ_DEPTH),
    .SQ_DEPTH (SQ_DEPTH)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .alloc_is_store (alloc_is_store),
    .alloc_ready    (alloc_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .slot_valid     (slot_valid),
    .slot_data_ok   (slot_data_ok),
    .grant          (grant),
    .slot_older     (slot_older),
    .slot_addr      (slot_addr)
);

// File: tb/ldst_order_buf_tb.sv
module ldst_order_buf_tb;
    import ldst_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_valid = 1'b0;
    logic              alloc_is_store = 1'b0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic [ID_W-1:0]   alloc_id = '0;
    logic              alloc_data_ok = 1'b0;
    logic [DATA_W-1:0] alloc_data = '0;
    logic [TAG_W-1:0]  alloc_tag = '0;
    logic              alloc_ready;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_data = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_data;
    logic [ID_W-1:0]   mem_req_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ldst_order_buf u_dut (.*);

    // Vector table: kind, address, data, id. Each goes through an empty buffer.
    localparam int NV = 6;
    localparam logic              V_ST   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{16'h0004, 16'h0008, 16'hFFFC, 16'h1234, 16'h0000, 16'h8000};
    localparam logic [DATA_W-1:0] V_DATA [NV] = '{32'h0, 32'hDEADBEEF, 32'h0, 32'h00000001, 32'hFFFFFFFF, 32'h0};
    localparam logic [ID_W-1:0]   V_ID   [NV] = '{6'd1, 6'd2, 6'd3, 6'd4, 6'd63, 6'd0};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_alloc(input bit st, input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id,
                            input bit dok, input logic [DATA_W-1:0] d, input logic [TAG_W-1:0] tg);
        alloc_valid    = 1'b1;
        alloc_is_store = st;
        alloc_addr     = a;
        alloc_id       = id;
        alloc_data_ok  = dok;
        alloc_data     = d;
        alloc_tag      = tg;
        tick();
        alloc_valid    = 1'b0;
    endtask

    task automatic accept();
        mem_req_ready = 1'b1;
        tick();
        mem_req_ready = 1'b0;
    endtask

    task automatic expect_req(input string req, input bit v, input bit w, input logic [ID_W-1:0] id,
                              input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        chk(mem_req_valid == v, {req, " valid"}, 64'(mem_req_valid), 64'(v));
        if (v) begin
            chk(mem_req_id == id, {req, " id"}, 64'(mem_req_id), 64'(id));
            chk(mem_req_write == w, {req, " write"}, 64'(mem_req_write), 64'(w));
            chk(mem_req_addr == a, {req, " addr"}, 64'(mem_req_addr), 64'(a));
            chk(mem_req_data == d, {req, " data"}, 64'(mem_req_data), 64'(d));
        end
    endtask

    task automatic expect_ready(input string req, input bit st, input bit exp);
        alloc_is_store = st;
        #1;
        chk(alloc_ready == exp, req, 64'(alloc_ready), 64'(exp));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        expect_ready("R1 load ready after reset", 1'b0, 1'b1);
        expect_ready("R1 store ready after reset", 1'b1, 1'b1);
        chk(mem_req_valid == 1'b0, "R1 no request after reset", 64'(mem_req_valid), 64'd0);

        // R2 / R9: table walk, one operation at a time
        for (int k = 0; k < NV; k++) begin
            do_alloc(V_ST[k], V_ADDR[k], V_ID[k], 1'b1, V_DATA[k], '0);
            expect_req(V_ST[k] ? "R9 table store" : "R2 table load", 1'b1, V_ST[k], V_ID[k],
                       V_ADDR[k], V_ST[k] ? V_DATA[k] : '0);
            accept();
            expect_req("R10 table drained", 1'b0, 1'b0, '0, '0, '0);
        end

        // R3 / R4 / R5: store waits on tag, same-address load waits on store
        do_alloc(1'b1, 16'h0010, 6'd1, 1'b0, '0, 4'd3);
        do_alloc(1'b0, 16'h0010, 6'd2, 1'b0, '0, '0);
        do_alloc(1'b0, 16'h0020, 6'd3, 1'b0, '0, '0);
        expect_req("R4 younger load passes blocked load", 1'b1, 1'b0, 6'd3, 16'h0020, '0);
        accept();
        expect_req("R3 load held behind same-address store", 1'b0, 1'b0, '0, '0, '0);
        bc_valid = 1'b1; bc_tag = 4'd2; bc_data = 32'h55555555;
        tick();
        bc_valid = 1'b0;
        expect_req("R5 store ignores other tag", 1'b0, 1'b0, '0, '0, '0);
        bc_valid = 1'b1; bc_tag = 4'd3; bc_data = 32'h0000ABCD;
        tick();
        bc_valid = 1'b0;
        expect_req("R5 store sends broadcast data", 1'b1, 1'b1, 6'd1, 16'h0010, 32'h0000ABCD);
        accept();
        expect_req("R3 load released after store", 1'b1, 1'b0, 6'd2, 16'h0010, '0);
        accept();
        expect_req("R10 drained after R3 case", 1'b0, 1'b0, '0, '0, '0);

        // R6: store behind older load and older store at the same address
        do_alloc(1'b0, 16'h0030, 6'd4, 1'b0, '0, '0);
        do_alloc(1'b1, 16'h0030, 6'd5, 1'b1, 32'h11111111, '0);
        do_alloc(1'b1, 16'h0030, 6'd6, 1'b1, 32'h22222222, '0);
        expect_req("R6 older load goes first", 1'b1, 1'b0, 6'd4, 16'h0030, '0);
        tick();
        expect_req("R6 request held while not accepted", 1'b1, 1'b0, 6'd4, 16'h0030, '0);
        accept();
        expect_req("R6 first store after load", 1'b1, 1'b1, 6'd5, 16'h0030, 32'h11111111);
        accept();
        expect_req("R6 second store after first", 1'b1, 1'b1, 6'd6, 16'h0030, 32'h22222222);
        accept();

        // R4: two loads to the same address go back to back
        do_alloc(1'b0, 16'h0040, 6'd7, 1'b0, '0, '0);
        do_alloc(1'b0, 16'h0040, 6'd8, 1'b0, '0, '0);
        expect_req("R4 first same-address load", 1'b1, 1'b0, 6'd7, 16'h0040, '0);
        accept();
        expect_req("R4 second same-address load next", 1'b1, 1'b0, 6'd8, 16'h0040, '0);
        accept();

        // R7: older store becoming ready takes the port from a younger load
        do_alloc(1'b1, 16'h0060, 6'd9, 1'b0, '0, 4'd2);
        do_alloc(1'b0, 16'h0070, 6'd10, 1'b0, '0, '0);
        expect_req("R7 younger load presented first", 1'b1, 1'b0, 6'd10, 16'h0070, '0);
        bc_valid = 1'b1; bc_tag = 4'd2; bc_data = 32'hCAFE0001;
        tick();
        bc_valid = 1'b0;
        expect_req("R7 oldest ready store wins", 1'b1, 1'b1, 6'd9, 16'h0060, 32'hCAFE0001);
        accept();
        expect_req("R7 load follows", 1'b1, 1'b0, 6'd10, 16'h0070, '0);
        accept();

        // R5: broadcast in the allocation cycle is captured
        bc_valid = 1'b1; bc_tag = 4'd7; bc_data = 32'h00001234;
        do_alloc(1'b1, 16'h0080, 6'd11, 1'b0, '0, 4'd7);
        bc_valid = 1'b0;
        expect_req("R5 same-cycle broadcast captured", 1'b1, 1'b1, 6'd11, 16'h0080, 32'h00001234);
        accept();

        // R8 / R10: full load queue
        for (int k = 0; k < 4; k++) begin
            do_alloc(1'b0, 16'h0100 + 16'(k), 6'(12 + k), 1'b0, '0, '0);
        end
        expect_ready("R8 load queue full", 1'b0, 1'b0);
        expect_ready("R8 store queue still free", 1'b1, 1'b1);
        do_alloc(1'b0, 16'h0200, 6'd20, 1'b0, '0, '0);
        expect_req("R8 oldest of full queue", 1'b1, 1'b0, 6'd12, 16'h0100, '0);
        accept();
        expect_ready("R10 slot free after accept", 1'b0, 1'b1);
        for (int k = 1; k < 4; k++) begin
            expect_req("R8 draining full queue", 1'b1, 1'b0, 6'(12 + k), 16'h0100 + 16'(k), '0);
            accept();
        end
        expect_req("R8 refused allocation left nothing", 1'b0, 1'b0, '0, '0, '0);

        summary();
    end
endmodule